// File: doc/BRIEF.md
# In-band Xon/Xoff Flow Controller

This block sits between a serial receiver, the receive FIFO it feeds and the transmitter that drains a local data source. It watches every received character for programmed stop and go codes, either as a single character or as a two-character pair. A matched stop code holds the local transmitter at the next character boundary. A matched go code releases it. Matched codes never reach the receive FIFO. In pair mode, a first character that turns out not to start a pair is written back into the stream in its original order.

The block also throttles the far end. It compares the receive FIFO occupancy with a selectable high/low pair of levels. When the FIFO fills up to the high level, the block sends the stop code or stop pair. When the FIFO later drains to the low level, it sends the go code or go pair. These injected codes go ahead of pending data and are sent even while the local transmitter is stopped by the far end.

Configuration arrives through a small write port: four code registers and one control register.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset, all four code registers read as 0x00 and the control register as 0. With matching enabled in single mode straight after reset, a received 0x00 therefore counts as a stop code. Address 0 is go-1, 1 is go-2, 2 is stop-1, 3 is stop-2 and 4 is control. The control fields are: bit0 enables matching, bit1 selects pair mode, bit2 enables automatic sending, bits4:3 select the level pair, and bit5 enables the interrupt.
- R2: In single mode, a received character equal to stop-1 sets `remote_stop` and `flow_flag` one clock after its strobe. While `remote_stop` is high and nothing is being injected, `tx_req` stays low and the pending source data is not popped.
- R3: In single mode, a received character equal to go-1 (and not equal to stop-1) clears `remote_stop` and `flow_flag`, and held data then resumes.
- R4: Received characters that are not recognised as codes appear on `fifo_wr`/`fifo_wdata` one clock after their strobe, in arrival order. Recognised codes are never written.
- R5: In pair mode, stop-1 immediately followed by stop-2 stops the transmitter, and go-1 followed by go-2 releases it. The first character alone changes nothing.
- R6: In pair mode, when a held first character is not followed by its partner, the held character is written first. The next character is written one clock later, unless it is itself stop-1 or go-1, in which case it becomes the new held character.
- R7: With automatic sending enabled, the stop code is queued once when `fifo_count` reaches the high level: 8, 16, 24 or 28 for select values 0..3. In pair mode the stop code is stop-1 then stop-2. It is not queued again until a go code has been sent.
- R8: After a stop code has been sent, the go code (go-1, or go-1 then go-2) is queued once when `fifo_count` falls to the low level: 0, 7, 15 or 23 for select values 0..3.
- R9: Queued codes are offered on `tx_char` in place of source data from the next clock. They are sent ahead of any pending data, and they are sent even while `remote_stop` is high.
- R10: `irq` equals `flow_flag` when the interrupt enable bit is set, and is 0 otherwise.
- R11: With matching disabled, every received character, including code values, is written to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| fifo_count | input | 6 | Current receive FIFO occupancy |
| fifo_wr | output | 1 | Write strobe into the receive FIFO |
| fifo_wdata | output | 8 | Character written into the receive FIFO |
| src_valid | input | 1 | Local transmit data available |
| src_data | input | 8 | Local transmit data |
| src_pop | output | 1 | Source data taken by the transmitter |
| tx_req | output | 1 | A character is offered to the transmitter |
| tx_char | output | 8 | Character offered to the transmitter |
| tx_ack | input | 1 | Transmitter accepts the offered character |
| remote_stop | output | 1 | Transmission of data stopped by the far end |
| flow_flag | output | 1 | Status: stop code received, cleared by go code |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach is an injected stop code competing with data that is already waiting. The injected code must win even though the source has been valid for many cycles. The bench reaches this state by stalling its transmitter model, loading a data byte and then raising the FIFO count across the high level. When it releases the transmitter, the accepted order must be stop-1, stop-2 and then the data. A second scenario first stops the transmitter from the far end, then crosses both levels. This shows that the codes still go out while the data stays held until a go code arrives.

// File: rtl/xflow_pkg.sv
// Shared types and level tables for the in-band flow controller.
package xflow_pkg;

    // Control register fields, most significant field first.
    typedef struct packed {
        logic       irq_en;
        logic [1:0] level_sel;
        logic       auto_tx;
        logic       pair_mode;
        logic       match_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // Kind of first character held while waiting for its partner.
    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_STOP = 2'd1,
        HOLD_GO   = 2'd2
    } hold_t;

    // High occupancy level at which the stop code is queued.
    function automatic int unsigned high_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 28;
        endcase
    endfunction

    // Low occupancy level at which the go code is queued.
    function automatic int unsigned low_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 7;
            2'd2:    return 15;
            default: return 23;
        endcase
    endfunction

endpackage

// File: rtl/xflow_regs.sv
// Register file: four code registers and a control register.
// Assumes single-cycle writes; unknown addresses are ignored.
module xflow_regs
    import xflow_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    output logic [CHAR_W-1:0] go1,
    output logic [CHAR_W-1:0] go2,
    output logic [CHAR_W-1:0] stop1,
    output logic [CHAR_W-1:0] stop2,
    output ctrl_t             ctrl
);

    localparam logic [ADDR_W-1:0] A_GO1   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_GO2   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STOP1 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_STOP2 = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(4);

    // Capture writes into the addressed register.
    always_ff @(posedge clk) begin : reg_write
        if (!rst_n) begin
            go1   <= '0;
            go2   <= '0;
            stop1 <= '0;
            stop2 <= '0;
            ctrl  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_GO1:   go1   <= cfg_wdata;
                A_GO2:   go2   <= cfg_wdata;
                A_STOP1: stop1 <= cfg_wdata;
                A_STOP2: stop2 <= cfg_wdata;
                A_CTRL:  ctrl  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xflow_rx_match.sv
// Receive-side matcher. Compares each received character with the code
// registers, updates the stop state and the status flag, and forwards
// non-code characters to the FIFO one clock later. In pair mode a
// possible first character is held; if its partner does not follow, the
// held character and the new one are replayed in order.
// Assumes received strobes are at least two clocks apart.
module xflow_rx_match
    import xflow_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_en,
    input  logic              pair_mode,
    input  logic [CHAR_W-1:0] go1,
    input  logic [CHAR_W-1:0] go2,
    input  logic [CHAR_W-1:0] stop1,
    input  logic [CHAR_W-1:0] stop2,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_wdata,
    output logic              remote_stop,
    output logic              flow_flag
);

    hold_t             held_kind;
    logic [CHAR_W-1:0] held_char;
    logic              spill_v;
    logic [CHAR_W-1:0] spill_char;

    logic              do_stop, do_go, wr_now, hold_set, hold_clr, spill_set;
    hold_t             hold_new;
    logic [CHAR_W-1:0] wr_char;
    logic [CHAR_W-1:0] partner;

    // Decide what the current received character does.
    always_comb begin : rx_decide
        do_stop   = 1'b0;
        do_go     = 1'b0;
        wr_now    = 1'b0;
        wr_char   = rx_data;
        hold_set  = 1'b0;
        hold_new  = HOLD_NONE;
        hold_clr  = 1'b0;
        spill_set = 1'b0;
        partner   = (held_kind == HOLD_STOP) ? stop2 : go2;
        if (rx_valid) begin
            if (!match_en || (!pair_mode && held_kind != HOLD_NONE)) begin
                if (held_kind != HOLD_NONE) begin
                    wr_now    = 1'b1;
                    wr_char   = held_char;
                    spill_set = 1'b1;
                    hold_clr  = 1'b1;
                end else begin
                    wr_now = 1'b1;
                end
            end else if (!pair_mode) begin
                if (rx_data == stop1) begin
                    do_stop = 1'b1;
                end else if (rx_data == go1) begin
                    do_go = 1'b1;
                end else begin
                    wr_now = 1'b1;
                end
            end else if (held_kind == HOLD_NONE) begin
                if (rx_data == stop1) begin
                    hold_set = 1'b1;
                    hold_new = HOLD_STOP;
                end else if (rx_data == go1) begin
                    hold_set = 1'b1;
                    hold_new = HOLD_GO;
                end else begin
                    wr_now = 1'b1;
                end
            end else if (rx_data == partner) begin
                do_stop  = (held_kind == HOLD_STOP);
                do_go    = (held_kind == HOLD_GO);
                hold_clr = 1'b1;
            end else begin
                wr_now  = 1'b1;
                wr_char = held_char;
                if (rx_data == stop1) begin
                    hold_set = 1'b1;
                    hold_new = HOLD_STOP;
                end else if (rx_data == go1) begin
                    hold_set = 1'b1;
                    hold_new = HOLD_GO;
                end else begin
                    spill_set = 1'b1;
                    hold_clr  = 1'b1;
                end
            end
        end
    end

    // Register the FIFO write, the replay slot and the held character.
    always_ff @(posedge clk) begin : rx_datapath
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            spill_v    <= 1'b0;
            spill_char <= '0;
            held_kind  <= HOLD_NONE;
            held_char  <= '0;
        end else begin
            fifo_wr <= 1'b0;
            spill_v <= 1'b0;
            if (spill_v) begin
                fifo_wr    <= 1'b1;
                fifo_wdata <= spill_char;
            end
            if (wr_now) begin
                fifo_wr    <= 1'b1;
                fifo_wdata <= wr_char;
            end
            if (spill_set) begin
                spill_v    <= 1'b1;
                spill_char <= rx_data;
            end
            if (hold_set) begin
                held_kind <= hold_new;
                held_char <= rx_data;
            end else if (hold_clr) begin
                held_kind <= HOLD_NONE;
            end
        end
    end

    // Track the far-end stop state and the status flag.
    always_ff @(posedge clk) begin : rx_state
        if (!rst_n) begin
            remote_stop <= 1'b0;
            flow_flag   <= 1'b0;
        end else if (do_stop) begin
            remote_stop <= 1'b1;
            flow_flag   <= 1'b1;
        end else if (do_go) begin
            remote_stop <= 1'b0;
            flow_flag   <= 1'b0;
        end
    end

    AST_SINGLE_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && match_en && !pair_mode && held_kind == HOLD_NONE && rx_data == stop1)
        |=> remote_stop) else $error("single stop code did not halt"); // R2
    AST_CODE_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && match_en && !pair_mode && held_kind == HOLD_NONE && !spill_v
         && (rx_data == stop1 || rx_data == go1))
        |=> !fifo_wr) else $error("code character reached the FIFO"); // R4
    AST_SINGLE_GO_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && match_en && !pair_mode && held_kind == HOLD_NONE
         && rx_data == go1 && rx_data != stop1)
        |=> !remote_stop) else $error("single go code did not release"); // R3
    AST_REPLAY_AFTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        spill_v |-> fifo_wr) else $error("replayed character without held write"); // R6
    AST_RX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        spill_v |-> !rx_valid) else $error("received strobes too close"); // R6

endmodule

// File: rtl/xflow_level_watch.sv
// Watches the receive FIFO occupancy and requests a stop code on reaching
// the high level and a go code on falling to the low level, once each,
// remembering which code was requested last.
// Assumes requests are taken only while the injector is idle.
module xflow_level_watch
    import xflow_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_tx,
    input  logic [1:0]       level_sel,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             inj_busy,
    output logic             start_stop,
    output logic             start_go
);

    logic        stop_sent;
    int unsigned count_i;

    // Compare occupancy with the selected level pair.
    always_comb begin : level_cmp
        count_i    = int'(fifo_count);
        start_stop = auto_tx && !inj_busy && !stop_sent && (count_i >= high_level(level_sel));
        start_go   = auto_tx && !inj_busy && stop_sent && (count_i <= low_level(level_sel));
    end

    // Record which code was requested last.
    always_ff @(posedge clk) begin : level_state
        if (!rst_n) begin
            stop_sent <= 1'b0;
        end else if (start_stop) begin
            stop_sent <= 1'b1;
        end else if (start_go) begin
            stop_sent <= 1'b0;
        end
    end

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stop, start_go})) else $error("both codes requested"); // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stop || start_go) |=> inj_busy) else $error("request not taken"); // R8

endmodule

// File: rtl/xflow_tx_arb.sv
// Transmit arbiter and code injector. Holds a one- or two-character code
// sequence and offers it ahead of source data; source data is offered only
// while the far end has not stopped us. A character is committed on
// tx_ack, so a queued code overtakes data at the next character boundary.
module xflow_tx_arb #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_mode,
    input  logic [CHAR_W-1:0] go1,
    input  logic [CHAR_W-1:0] go2,
    input  logic [CHAR_W-1:0] stop1,
    input  logic [CHAR_W-1:0] stop2,
    input  logic              start_stop,
    input  logic              start_go,
    input  logic              remote_stop,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_data,
    input  logic              tx_ack,
    output logic              src_pop,
    output logic              tx_req,
    output logic [CHAR_W-1:0] tx_char,
    output logic              inj_busy
);

    logic              inj_go;
    logic              inj_two;
    logic              inj_phase;
    logic [CHAR_W-1:0] inj_char;
    logic              data_ok;

    // Select the offered character and the pop strobe.
    always_comb begin : tx_select
        if (inj_go) begin
            inj_char = inj_phase ? go2 : go1;
        end else begin
            inj_char = inj_phase ? stop2 : stop1;
        end
        data_ok = src_valid && !remote_stop;
        tx_req  = inj_busy || data_ok;
        tx_char = inj_busy ? inj_char : src_data;
        src_pop = tx_ack && !inj_busy && data_ok;
    end

    // Step through the queued code sequence.
    always_ff @(posedge clk) begin : inj_seq
        if (!rst_n) begin
            inj_busy  <= 1'b0;
            inj_go    <= 1'b0;
            inj_two   <= 1'b0;
            inj_phase <= 1'b0;
        end else if (!inj_busy) begin
            if (start_stop || start_go) begin
                inj_busy  <= 1'b1;
                inj_go    <= start_go;
                inj_two   <= pair_mode;
                inj_phase <= 1'b0;
            end
        end else if (tx_ack) begin
            if (inj_two && !inj_phase) begin
                inj_phase <= 1'b1;
            end else begin
                inj_busy <= 1'b0;
            end
        end
    end

    AST_STOP_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_stop && !inj_busy) |-> !tx_req) else $error("data offered while stopped"); // R2
    AST_CODE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_busy && tx_ack) |-> !src_pop) else $error("data taken during code"); // R9

endmodule

// File: rtl/xflow_ctrl.sv
// Top of the in-band flow controller: register file, receive matcher,
// level watcher and transmit arbiter. Assumes the FIFO count is already
// synchronous to clk and received strobes are at least two clocks apart.
module xflow_ctrl
    import xflow_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_wdata,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_data,
    output logic              src_pop,
    output logic              tx_req,
    output logic [CHAR_W-1:0] tx_char,
    input  logic              tx_ack,
    output logic              remote_stop,
    output logic              flow_flag,
    output logic              irq
);

    logic [CHAR_W-1:0] go1, go2, stop1, stop2;
    ctrl_t             ctrl;
    logic              start_stop, start_go, inj_busy;

    xflow_regs #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .go1(go1), .go2(go2), .stop1(stop1),
        .stop2(stop2), .ctrl(ctrl)
    );

    xflow_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .match_en(ctrl.match_en),
        .pair_mode(ctrl.pair_mode), .go1(go1), .go2(go2), .stop1(stop1),
        .stop2(stop2), .rx_valid(rx_valid), .rx_data(rx_data),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .remote_stop(remote_stop), .flow_flag(flow_flag)
    );

    xflow_level_watch #(.CNT_W(CNT_W)) u_level (
        .clk(clk), .rst_n(rst_n), .auto_tx(ctrl.auto_tx),
        .level_sel(ctrl.level_sel), .fifo_count(fifo_count),
        .inj_busy(inj_busy), .start_stop(start_stop), .start_go(start_go)
    );

    xflow_tx_arb #(.CHAR_W(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .pair_mode(ctrl.pair_mode), .go1(go1),
        .go2(go2), .stop1(stop1), .stop2(stop2), .start_stop(start_stop),
        .start_go(start_go), .remote_stop(remote_stop),
        .src_valid(src_valid), .src_data(src_data), .tx_ack(tx_ack),
        .src_pop(src_pop), .tx_req(tx_req), .tx_char(tx_char),
        .inj_busy(inj_busy)
    );

    // Gate the status flag onto the interrupt output.
    always_comb begin : irq_gate
        irq = flow_flag && ctrl.irq_en;
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.irq_en) |-> !irq) else $error("interrupt while masked"); // R10

endmodule

// File: tb/xflow_ctrl_test.sv
`timescale 1ns/1ps
module xflow_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [5:0] fifo_count;
    logic       fifo_wr;
    logic [7:0] fifo_wdata;
    logic       src_valid;
    logic [7:0] src_data;
    logic       src_pop;
    logic       tx_req;
    logic [7:0] tx_char;
    logic       tx_ack;
    logic       remote_stop;
    logic       flow_flag;
    logic       irq;

    always #2 clk = ~clk;

    xflow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .fifo_count(fifo_count), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
        .tx_req(tx_req), .tx_char(tx_char), .tx_ack(tx_ack),
        .remote_stop(remote_stop), .flow_flag(flow_flag), .irq(irq)
    );

    int         checks = 0;
    int         failures = 0;
    bit         done = 0;
    bit         tx_hold = 0;
    int         gap = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];
    logic [7:0] src_q[$];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compare FIFO writes and accepted characters with the queues.
    initial forever begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            if (fifo_wr) begin
                if (exp_rx.size() == 0) check("R4 unexpected FIFO write", fifo_wdata, 'h100);
                else check("R4 R6 R11 FIFO data order", fifo_wdata, exp_rx.pop_front());
            end
            if (tx_req && tx_ack) begin
                if (exp_tx.size() == 0) check("R7 R8 R9 unexpected transmit", tx_char, 'h100);
                else check("R7 R8 R9 transmit order", tx_char, exp_tx.pop_front());
            end
            if (src_pop && src_q.size() != 0) void'(src_q.pop_front());
        end
    end

    // Source model: presents the head of the source queue.
    initial forever begin
        @(posedge clk);
        #0.5;
        src_valid = (src_q.size() != 0);
        src_data  = (src_q.size() != 0) ? src_q[0] : 8'h00;
    end

    // Transmitter model: accepts one character, then is busy for a while.
    initial begin
        tx_ack = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (tx_ack) begin
                tx_ack = 1'b0;
                gap = 3;
            end else if (gap > 0) begin
                gap--;
            end else if (tx_req && !tx_hold) begin
                tx_ack = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #0.5;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #0.5;
        cfg_we = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(posedge clk); #0.5;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #0.5;
        rx_valid = 1'b0;
        repeat (3) @(posedge clk);
        #0.5;
    endtask

    task automatic set_count(input int c);
        @(posedge clk); #0.5;
        fifo_count = 6'(c);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic sample();
        @(posedge clk); #3;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300 && exp_tx.size() != 0; i++) @(posedge clk);
        idle(4);
        check(req, exp_tx.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; fifo_count = '0;
        idle(3);
        sample();
        check("R1 reset fifo_wr", fifo_wr, 0);
        check("R1 reset tx_req", tx_req, 0);
        check("R1 reset remote_stop", remote_stop, 0);
        check("R10 reset irq", irq, 0);
        rst_n = 1'b1;
        idle(2);

        // R11: matching off, code values pass through.
        exp_rx.push_back(8'h00); exp_rx.push_back(8'h41);
        rx_send(8'h00); rx_send(8'h41);
        check("R11 not stopped", remote_stop, 0);

        // R1: reset code value 0x00 acts as a stop code.
        wr_reg(3'd4, 8'h01);
        rx_send(8'h00);
        check("R1 zero code stops", remote_stop, 1);
        check("R10 irq masked", irq, 0);
        wr_reg(3'd0, 8'h11); wr_reg(3'd2, 8'h13);
        rx_send(8'h11);
        check("R3 go releases", remote_stop, 0);

        // R2, R3, R10: stop holds data, go resumes it.
        wr_reg(3'd4, 8'h21);
        rx_send(8'h13);
        check("R2 stopped", remote_stop, 1);
        check("R2 flag", flow_flag, 1);
        check("R10 irq set", irq, 1);
        src_q.push_back(8'h55);
        idle(12);
        sample();
        check("R2 tx_req low while stopped", tx_req, 0);
        check("R2 data still pending", src_q.size(), 1);
        exp_tx.push_back(8'h55);
        rx_send(8'h11);
        check("R3 released", remote_stop, 0);
        check("R3 flag cleared", flow_flag, 0);
        check("R10 irq cleared", irq, 0);
        drain("R3 held data sent");

        // R4: codes removed, data in order.
        exp_rx.push_back(8'h20); exp_rx.push_back(8'h21);
        rx_send(8'h20); rx_send(8'h13); rx_send(8'h21);
        rx_send(8'h11);
        check("R4 released again", remote_stop, 0);

        // R5: pair mode.
        wr_reg(3'd1, 8'h12); wr_reg(3'd3, 8'h14); wr_reg(3'd4, 8'h23);
        rx_send(8'h13);
        check("R5 first half no effect", remote_stop, 0);
        rx_send(8'h14);
        check("R5 pair stops", remote_stop, 1);
        rx_send(8'h11); rx_send(8'h12);
        check("R5 pair releases", remote_stop, 0);

        // R6: broken pairs replayed in order.
        exp_rx.push_back(8'h13); exp_rx.push_back(8'h30);
        rx_send(8'h13); rx_send(8'h30);
        exp_rx.push_back(8'h11);
        rx_send(8'h11); rx_send(8'h13); rx_send(8'h14);
        check("R6 re-held first half completes pair", remote_stop, 1);
        rx_send(8'h11); rx_send(8'h12);
        check("R6 release", remote_stop, 0);

        // R7, R8, R9: level 1 (16 / 7) in pair mode, code ahead of data.
        set_count(0);
        tx_hold = 1;
        wr_reg(3'd4, 8'h0F);
        src_q.push_back(8'h66);
        set_count(15);
        idle(3);
        sample();
        check("R7 below high level offers data", tx_char, 8'h66);
        set_count(16);
        sample();
        sample();
        check("R9 code overtakes data", tx_char, 8'h13);
        exp_tx.push_back(8'h13); exp_tx.push_back(8'h14); exp_tx.push_back(8'h66);
        tx_hold = 0;
        drain("R9 stop pair then data");
        set_count(20); idle(20);
        set_count(8);  idle(20);
        check("R7 stop sent once", exp_tx.size(), 0);
        exp_tx.push_back(8'h11); exp_tx.push_back(8'h12);
        set_count(7);
        drain("R8 go pair at low level");
        set_count(3); idle(20);

        // R9: codes go out while stopped by far end; level 3 (28 / 23).
        set_count(0);
        wr_reg(3'd4, 8'h1D);
        rx_send(8'h13);
        check("R9 stopped by far end", remote_stop, 1);
        src_q.push_back(8'h77);
        exp_tx.push_back(8'h13);
        set_count(27); idle(10);
        set_count(28);
        drain("R9 stop code sent while stopped");
        check("R2 data held", src_q.size(), 1);
        exp_tx.push_back(8'h11);
        set_count(23);
        drain("R8 go code sent while stopped");
        exp_tx.push_back(8'h77);
        rx_send(8'h11);
        drain("R3 data after release");

        // R7, R8: level 0 (8 / 0).
        set_count(0);
        wr_reg(3'd4, 8'h05);
        exp_tx.push_back(8'h13);
        set_count(8);
        drain("R7 level 0 stop");
        set_count(1); idle(20);
        exp_tx.push_back(8'h11);
        set_count(0);
        drain("R8 level 0 go");

        idle(10);
        check("R4 all FIFO writes seen", exp_rx.size(), 0);
        check("R9 all transmits seen", exp_tx.size(), 0);
        finish_run();
    end

endmodule